// File: doc/BRIEF.md
# Multichannel ADC Serial Command Front End

This block is the device side of a serial-port analog-to-digital converter. A host writes one-byte commands over an SPI mode 0 link. The leading set bit among the top four bits of each byte picks the register it loads. Loading the conversion register starts one of four sequences: a single channel, a run from channel 0 up, a run from a chosen channel to the top, or a repeated channel. Each sequence can also measure temperature first. Samples come from a stubbed source: one 10-bit value per voltage channel and one 12-bit temperature value, driven on input ports.

Each conversion takes a fixed number of clock cycles, set by a parameter. Averaging multiplies that time by the number of samples averaged. When every result of the sequence is stored, the active-low end-of-conversion line falls. The host then clocks the results out, most significant byte first, two bytes per result. A conversion can start on the command write itself, or it can wait for an external start pulse, depending on the clock-mode field of the setup register.

Top module: `adc_spi_frontend`

## Requirements
- R1: Each received byte is decoded by its highest set bit among bits 7:4. Bit 7 loads the conversion register, bit 6 the setup register, bit 5 the averaging register and bit 4 is the reset command. A byte whose bits 7:4 are all zero changes nothing, but it still advances the read position.
- R2: A conversion byte carries the channel N in bits 6:3, the scan mode in bits 2:1 and a temperature request in bit 0. A channel value at or above the channel count is treated as the highest channel.
- R3: Scan mode 00 converts channels 0 up to N in ascending order.
- R4: Scan mode 01 converts channels N up to the highest channel in ascending order.
- R5: Scan mode 10 converts channel N repeatedly. The count is 4, 8, 12 or 16 for averaging-register bits 1:0 equal to 00, 01, 10 or 11.
- R6: Scan mode 11 converts channel N exactly once.
- R7: If temperature is requested, its result comes first, as the word {4'b0, t[11:0]}. Each voltage result is the word {4'b0, v[9:0], 2'b00}. MISO sends each word high byte first, bit 7 first. It changes only after a falling SCLK edge or at chip-select assertion. MOSI is sampled on rising SCLK edges.
- R8: The read position returns to the first result byte each time a sequence completes. It advances by one for every byte exchanged and carries across chip-select frames. Bytes read beyond the last stored result are 0x00.
- R9: With setup bits 5:4 equal to 00, a conversion byte is only stored. Each falling edge of the external start line then launches the stored sequence. With any other value, writing the conversion byte launches the sequence, and the start line has no effect.
- R10: eoc_n is high out of reset. It goes high when a sequence launches and falls once the last result of the sequence is stored. It stays low until the next launch or reset command.
- R11: Averaging-register bit 4 enables averaging, and bits 3:2 select 4, 8, 16 or 32 samples. Each result is then the floor of the mean of that many samples, each taking CONV_CYC cycles. With bit 4 clear, each result takes one sample.
- R12: The reset command clears the conversion, setup and averaging registers. It discards the stored results and drives eoc_n high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock; SPI and start inputs are oversampled on it |
| rst_n | input | 1 | Asynchronous active-low reset |
| spi_sclk | input | 1 | SPI serial clock, idles low (mode 0) |
| spi_cs_n | input | 1 | SPI chip select, active low |
| spi_mosi | input | 1 | Command data from host |
| spi_miso | output | 1 | Result data to host |
| cnv_start_n | input | 1 | External conversion start, falling edge active |
| chan_samples | input | NCH*10 | Stub sample value of each voltage channel, channel 0 in the low bits |
| temp_sample | input | 12 | Stub temperature sample |
| eoc_n | output | 1 | End of conversion, active low |

## Verification
The bench sweeps every channel through every scan mode on an 8-channel build, including the clamped out-of-range channel field. A wrong mode decode or an off-by-one end channel shows up as a missing result, an extra result, or zeros where a result was expected. Reads run past the end of the results and are split across frames. This catches a read position that wraps into stale entries or restarts on chip select. The bench times each averaged conversion against the expected sample count and checks that a reset also clears the averaging and clock-mode settings. It also checks that start pulses are ignored outside the external-start mode and that a byte with an empty top nibble neither relaunches nor disturbs the readout.

// File: rtl/adcfe_pkg.sv
package adcfe_pkg;

  localparam int VBITS   = 10;
  localparam int TBITS   = 12;
  localparam int CH_W    = 4;
  localparam int MAX_REP = 16;

  typedef enum logic [1:0] {
    SCAN_LOW_UP  = 2'b00,
    SCAN_UP_HIGH = 2'b01,
    SCAN_REPEAT  = 2'b10,
    SCAN_SINGLE  = 2'b11
  } scan_e;

  typedef enum logic [1:0] {
    S_IDLE = 2'd0,
    S_RUN  = 2'd1,
    S_DONE = 2'd2
  } seq_state_e;

  typedef struct packed {
    logic [CH_W-1:0] ch;
    scan_e           scan;
    logic            temp;
  } conv_cfg_t;

  typedef struct packed {
    logic       en;
    logic [1:0] navg;
    logic [1:0] nscan;
  } avg_cfg_t;

endpackage

// File: rtl/afe_spi_port.sv
module afe_spi_port #(
  parameter int PTR_W = 6
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             sclk_i,
  input  logic             cs_n_i,
  input  logic             mosi_i,
  input  logic             ptr_clr_i,
  input  logic [7:0]       tx_byte_i,
  output logic [PTR_W-1:0] rd_ptr_o,
  output logic             byte_stb_o,
  output logic [7:0]       byte_o,
  output logic             miso_o
);

  logic [2:0] sclk_sh_q, cs_sh_q;
  logic [1:0] mosi_sh_q;
  logic [6:0] rx_q, rx_d;
  logic [2:0] bit_q, bit_d;
  logic [7:0] tx_q, tx_d;
  logic [PTR_W-1:0] ptr_q, ptr_d;
  logic cs_act, sclk_rise, sclk_fall, cs_fall, mosi_s, stb;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sclk_sh_q <= 3'b000;
      cs_sh_q   <= 3'b111;
      mosi_sh_q <= 2'b00;
    end else begin
      sclk_sh_q <= {sclk_sh_q[1:0], sclk_i};
      cs_sh_q   <= {cs_sh_q[1:0], cs_n_i};
      mosi_sh_q <= {mosi_sh_q[0], mosi_i};
    end
  end

  assign cs_act    = !cs_sh_q[1];
  assign sclk_rise = cs_act && sclk_sh_q[1] && !sclk_sh_q[2];
  assign sclk_fall = cs_act && !sclk_sh_q[1] && sclk_sh_q[2];
  assign cs_fall   = !cs_sh_q[1] && cs_sh_q[2];
  assign mosi_s    = mosi_sh_q[1];

  always_comb begin
    rx_d  = rx_q;
    bit_d = bit_q;
    tx_d  = tx_q;
    ptr_d = ptr_q;
    stb   = 1'b0;
    if (!cs_act) begin
      bit_d = 3'd0;
    end
    if (cs_fall) begin
      tx_d  = tx_byte_i;
      bit_d = 3'd0;
    end else if (sclk_rise) begin
      rx_d  = {rx_q[5:0], mosi_s};
      bit_d = bit_q + 3'd1;
      if (bit_q == 3'd7) begin
        stb = 1'b1;
        if (ptr_q != '1) ptr_d = ptr_q + 1'b1;
      end
    end else if (sclk_fall) begin
      if (bit_q == 3'd0) tx_d = tx_byte_i;
      else               tx_d = {tx_q[6:0], 1'b0};
    end
    if (ptr_clr_i) ptr_d = '0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rx_q  <= '0;
      bit_q <= '0;
      tx_q  <= '0;
      ptr_q <= '0;
    end else begin
      rx_q  <= rx_d;
      bit_q <= bit_d;
      tx_q  <= tx_d;
      ptr_q <= ptr_d;
    end
  end

  assign byte_stb_o = stb;
  assign byte_o     = {rx_q, mosi_s};
  assign rd_ptr_o   = ptr_q;
  assign miso_o     = tx_q[7];

  // R7: output bit moves only on a falling clock edge or select assertion
  p_miso_fall_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (!sclk_fall && !cs_fall) |=> $stable(miso_o));

endmodule

// File: rtl/afe_cmd_regs.sv
module afe_cmd_regs
  import adcfe_pkg::*;
(
  input  logic      clk,
  input  logic      rst_n,
  input  logic      byte_stb_i,
  input  logic [7:0] byte_i,
  input  logic      start_n_i,
  output conv_cfg_t conv_o,
  output avg_cfg_t  avg_o,
  output logic      go_o,
  output logic      clr_o
);

  localparam logic [1:0] CKS_EXT = 2'b00;

  conv_cfg_t  conv_q, conv_d;
  avg_cfg_t   avg_q, avg_d;
  logic [1:0] cks_q, cks_d;
  logic       pend_q, pend_d;
  logic       go_q, go_d, clr_q, clr_d;
  logic [2:0] st_sh_q;
  logic       st_fall;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) st_sh_q <= 3'b111;
    else        st_sh_q <= {st_sh_q[1:0], start_n_i};
  end

  assign st_fall = !st_sh_q[1] && st_sh_q[2];

  always_comb begin
    conv_d = conv_q;
    avg_d  = avg_q;
    cks_d  = cks_q;
    pend_d = pend_q;
    go_d   = 1'b0;
    clr_d  = 1'b0;
    if (byte_stb_i) begin
      if (byte_i[7]) begin
        conv_d = conv_cfg_t'(byte_i[6:0]);
        pend_d = 1'b1;
        if (cks_q != CKS_EXT) go_d = 1'b1;
      end else if (byte_i[6]) begin
        cks_d = byte_i[5:4];
      end else if (byte_i[5]) begin
        avg_d = avg_cfg_t'(byte_i[4:0]);
      end else if (byte_i[4]) begin
        conv_d = '0;
        avg_d  = '0;
        cks_d  = '0;
        pend_d = 1'b0;
        clr_d  = 1'b1;
      end
    end else if (st_fall && (cks_q == CKS_EXT) && pend_q) begin
      go_d = 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      conv_q <= '0;
      avg_q  <= '0;
      cks_q  <= '0;
      pend_q <= 1'b0;
      go_q   <= 1'b0;
      clr_q  <= 1'b0;
    end else begin
      conv_q <= conv_d;
      avg_q  <= avg_d;
      cks_q  <= cks_d;
      pend_q <= pend_d;
      go_q   <= go_d;
      clr_q  <= clr_d;
    end
  end

  assign conv_o = conv_q;
  assign avg_o  = avg_q;
  assign go_o   = go_q;
  assign clr_o  = clr_q;

  // R12: reset command leaves every register cleared
  p_clear_r12: assert property (@(posedge clk) disable iff (!rst_n)
    (byte_stb_i && byte_i[7:4] == 4'b0001) |=>
      (conv_q == '0 && avg_q == '0 && cks_q == 2'b00 && !pend_q && clr_q));

  // R1: a byte with an empty top nibble changes nothing
  p_ignore_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (byte_stb_i && byte_i[7:4] == 4'b0000) |=>
      ($stable(conv_q) && $stable(avg_q) && $stable(cks_q) && !go_q && !clr_q));

  // R9: a launch comes only from a conversion byte or an external start edge
  p_go_src_r9: assert property (@(posedge clk) disable iff (!rst_n)
    go_q |-> ($past(byte_stb_i && byte_i[7]) || $past(st_fall)));

endmodule

// File: rtl/afe_conv_seq.sv
module afe_conv_seq
  import adcfe_pkg::*;
#(
  parameter int NCH      = 8,
  parameter int CONV_CYC = 64,
  parameter int DEPTH    = 17,
  parameter int WIDX_W   = 5,
  parameter int PTR_W    = 6
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             go_i,
  input  logic             clr_i,
  input  conv_cfg_t        conv_i,
  input  avg_cfg_t         avg_i,
  input  logic [NCH*VBITS-1:0] volt_i,
  input  logic [TBITS-1:0] temp_i,
  input  logic [PTR_W-1:0] rd_ptr_i,
  output logic             eoc_n_o,
  output logic             done_o,
  output logic [7:0]       tx_byte_o
);

  localparam int TICK_W = (CONV_CYC > 2) ? $clog2(CONV_CYC) : 1;
  localparam int ACC_W  = TBITS + 5;
  localparam logic [CH_W-1:0]   LASTCH = CH_W'(NCH - 1);
  localparam logic [TICK_W-1:0] TICK_END = TICK_W'(CONV_CYC - 1);

  seq_state_e         st_q, st_d;
  logic               tmp_q, tmp_d;
  logic [CH_W-1:0]    ch_q, ch_d, last_q, last_d;
  logic [4:0]         rep_q, rep_d, reps_q, reps_d;
  logic [TICK_W-1:0]  tick_q, tick_d;
  logic [4:0]         samp_q, samp_d, slim_q, slim_d;
  logic [2:0]         shift_q, shift_d;
  logic [ACC_W-1:0]   acc_q, acc_d;
  logic [WIDX_W-1:0]  widx_q, widx_d, cnt_q, cnt_d;
  logic               eoc_q, eoc_d, done_q, done_d;
  logic               wr_en;

  logic [CH_W-1:0]    nsel;
  logic [ACC_W-1:0]   sample, acc_sum, avg_val;
  logic [15:0]        word;
  logic [15:0]        mem_q [DEPTH];

  assign nsel    = (conv_i.ch > LASTCH) ? LASTCH : conv_i.ch;
  assign sample  = tmp_q ? ACC_W'(temp_i) : ACC_W'(volt_i[VBITS*int'(ch_q) +: VBITS]);
  assign acc_sum = acc_q + sample;
  assign avg_val = acc_sum >> shift_q;
  assign word    = tmp_q ? {4'b0000, avg_val[TBITS-1:0]}
                         : {4'b0000, avg_val[VBITS-1:0], 2'b00};

  always_comb begin
    st_d    = st_q;
    tmp_d   = tmp_q;
    ch_d    = ch_q;
    last_d  = last_q;
    rep_d   = rep_q;
    reps_d  = reps_q;
    tick_d  = tick_q;
    samp_d  = samp_q;
    slim_d  = slim_q;
    shift_d = shift_q;
    acc_d   = acc_q;
    widx_d  = widx_q;
    cnt_d   = cnt_q;
    eoc_d   = eoc_q;
    done_d  = 1'b0;
    wr_en   = 1'b0;
    if (clr_i) begin
      st_d  = S_IDLE;
      cnt_d = '0;
      eoc_d = 1'b1;
    end else if (go_i) begin
      st_d    = S_RUN;
      eoc_d   = 1'b1;
      cnt_d   = '0;
      widx_d  = '0;
      tick_d  = '0;
      samp_d  = '0;
      acc_d   = '0;
      tmp_d   = conv_i.temp;
      slim_d  = avg_i.en ? 5'((4 << avg_i.navg) - 1) : 5'd0;
      shift_d = avg_i.en ? 3'(2 + avg_i.navg) : 3'd0;
      case (conv_i.scan)
        SCAN_LOW_UP:  begin ch_d = '0;   last_d = nsel;   reps_d = 5'd1; end
        SCAN_UP_HIGH: begin ch_d = nsel; last_d = LASTCH; reps_d = 5'd1; end
        SCAN_REPEAT:  begin ch_d = nsel; last_d = nsel;
                            reps_d = 5'({3'b000, avg_i.nscan} * 4 + 4); end
        default:      begin ch_d = nsel; last_d = nsel;   reps_d = 5'd1; end
      endcase
      rep_d = reps_d;
    end else if (st_q == S_RUN) begin
      if (tick_q == TICK_END) begin
        tick_d = '0;
        if (samp_q == slim_q) begin
          wr_en  = 1'b1;
          widx_d = widx_q + 1'b1;
          samp_d = '0;
          acc_d  = '0;
          if (tmp_q) begin
            tmp_d = 1'b0;
          end else if (rep_q > 5'd1) begin
            rep_d = rep_q - 5'd1;
          end else if (ch_q == last_q) begin
            st_d   = S_DONE;
            cnt_d  = widx_q + 1'b1;
            eoc_d  = 1'b0;
            done_d = 1'b1;
          end else begin
            ch_d  = ch_q + 1'b1;
            rep_d = reps_q;
          end
        end else begin
          samp_d = samp_q + 5'd1;
          acc_d  = acc_sum;
        end
      end else begin
        tick_d = tick_q + 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q    <= S_IDLE;
      tmp_q   <= 1'b0;
      ch_q    <= '0;
      last_q  <= '0;
      rep_q   <= '0;
      reps_q  <= '0;
      tick_q  <= '0;
      samp_q  <= '0;
      slim_q  <= '0;
      shift_q <= '0;
      acc_q   <= '0;
      widx_q  <= '0;
      cnt_q   <= '0;
      eoc_q   <= 1'b1;
      done_q  <= 1'b0;
    end else begin
      st_q    <= st_d;
      tmp_q   <= tmp_d;
      ch_q    <= ch_d;
      last_q  <= last_d;
      rep_q   <= rep_d;
      reps_q  <= reps_d;
      tick_q  <= tick_d;
      samp_q  <= samp_d;
      slim_q  <= slim_d;
      shift_q <= shift_d;
      acc_q   <= acc_d;
      widx_q  <= widx_d;
      cnt_q   <= cnt_d;
      eoc_q   <= eoc_d;
      done_q  <= done_d;
    end
  end

  always_ff @(posedge clk) begin
    if (wr_en) mem_q[widx_q] <= word;
  end

  logic [WIDX_W-1:0] rword;
  logic [15:0]       rdat;
  assign rword     = rd_ptr_i[PTR_W-1:1];
  assign rdat      = mem_q[rword];
  assign tx_byte_o = (rword < cnt_q) ? (rd_ptr_i[0] ? rdat[7:0] : rdat[15:8]) : 8'h00;
  assign eoc_n_o   = eoc_q;
  assign done_o    = done_q;

  // R10: end-of-conversion stays released while a sequence runs
  p_eoc_busy_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == S_RUN) |-> eoc_n_o);

  // R10: end-of-conversion falls only as a running sequence completes
  p_eoc_fall_r10: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(eoc_n_o) |-> $past(st_q == S_RUN));

  // R10: a launch releases end-of-conversion and starts running
  p_go_run_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (go_i && !clr_i) |=> (eoc_n_o && st_q == S_RUN));

  // R8: stored result count never exceeds the result storage
  p_cnt_bound_r8: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_q <= WIDX_W'(DEPTH));

endmodule

// File: rtl/adc_spi_frontend.sv
module adc_spi_frontend
  import adcfe_pkg::*;
#(
  parameter int NCH      = 8,
  parameter int CONV_CYC = 64
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 spi_sclk,
  input  logic                 spi_cs_n,
  input  logic                 spi_mosi,
  output logic                 spi_miso,
  input  logic                 cnv_start_n,
  input  logic [NCH*VBITS-1:0] chan_samples,
  input  logic [TBITS-1:0]     temp_sample,
  output logic                 eoc_n
);

  localparam int DEPTH  = ((NCH > MAX_REP) ? NCH : MAX_REP) + 1;
  localparam int WIDX_W = $clog2(DEPTH + 1);
  localparam int PTR_W  = WIDX_W + 1;

  logic [PTR_W-1:0] rd_ptr;
  logic             byte_stb, go, clr, done;
  logic [7:0]       rx_byte, tx_byte;
  conv_cfg_t        conv_cfg;
  avg_cfg_t         avg_cfg;

  afe_spi_port #(.PTR_W(PTR_W)) u_port (
    .clk        (clk),
    .rst_n      (rst_n),
    .sclk_i     (spi_sclk),
    .cs_n_i     (spi_cs_n),
    .mosi_i     (spi_mosi),
    .ptr_clr_i  (done | clr),
    .tx_byte_i  (tx_byte),
    .rd_ptr_o   (rd_ptr),
    .byte_stb_o (byte_stb),
    .byte_o     (rx_byte),
    .miso_o     (spi_miso)
  );

  afe_cmd_regs u_regs (
    .clk        (clk),
    .rst_n      (rst_n),
    .byte_stb_i (byte_stb),
    .byte_i     (rx_byte),
    .start_n_i  (cnv_start_n),
    .conv_o     (conv_cfg),
    .avg_o      (avg_cfg),
    .go_o       (go),
    .clr_o      (clr)
  );

  afe_conv_seq #(
    .NCH      (NCH),
    .CONV_CYC (CONV_CYC),
    .DEPTH    (DEPTH),
    .WIDX_W   (WIDX_W),
    .PTR_W    (PTR_W)
  ) u_seq (
    .clk       (clk),
    .rst_n     (rst_n),
    .go_i      (go),
    .clr_i     (clr),
    .conv_i    (conv_cfg),
    .avg_i     (avg_cfg),
    .volt_i    (chan_samples),
    .temp_i    (temp_sample),
    .rd_ptr_i  (rd_ptr),
    .eoc_n_o   (eoc_n),
    .done_o    (done),
    .tx_byte_o (tx_byte)
  );

endmodule

// File: tb/adc_spi_frontend_tb_top.sv
module adc_spi_frontend_tb_top;

  localparam int NCH  = 8;
  localparam int CC   = 40;
  localparam int H    = 8;
  localparam logic [11:0] TEMP_V = 12'hB37;

  logic clk, rst_n, sclk, cs_n, mosi, miso, start_n, eoc_n;
  logic [NCH*10-1:0] samples;

  int nchk, nerr;
  logic [15:0] exp_w [0:63];
  int exp_n;

  adc_spi_frontend #(.NCH(NCH), .CONV_CYC(CC)) dut_i (
    .clk          (clk),
    .rst_n        (rst_n),
    .spi_sclk     (sclk),
    .spi_cs_n     (cs_n),
    .spi_mosi     (mosi),
    .spi_miso     (miso),
    .cnv_start_n  (start_n),
    .chan_samples (samples),
    .temp_sample  (TEMP_V),
    .eoc_n        (eoc_n)
  );

  initial clk = 1'b0;
  always #4 clk = ~clk;

  function automatic logic [9:0] vsamp(int i);
    return 10'((i * 93 + 41) % 1024);
  endfunction

  task automatic check(string req, int act, int expv);
    nchk++;
    if (act != expv) begin
      nerr++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, expv);
    end
  endtask

  task automatic waitc(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic xfer(input logic [7:0] tx, output logic [7:0] rx);
    for (int b = 7; b >= 0; b--) begin
      mosi = tx[b];
      waitc(H);
      rx[b] = miso;
      sclk = 1'b1;
      waitc(H);
      sclk = 1'b0;
    end
  endtask

  task automatic fbegin();
    cs_n = 1'b0;
    waitc(H);
  endtask

  task automatic fend();
    waitc(H);
    cs_n = 1'b1;
    waitc(H);
  endtask

  task automatic send_cmd(input logic [7:0] c);
    logic [7:0] d;
    fbegin();
    xfer(c, d);
    fend();
  endtask

  task automatic wait_eoc(output int lat);
    int n;
    n = 0;
    while (eoc_n && n < 5000) begin
      @(negedge clk);
      n++;
    end
    lat = n + 3 * H;
  endtask

  function automatic int exp_byte(int k);
    int w;
    w = k / 2;
    if (w >= exp_n) return 0;
    return (k % 2 == 0) ? int'(exp_w[w][15:8]) : int'(exp_w[w][7:0]);
  endfunction

  task automatic build_exp(int scan, int n, bit t, int nscan);
    int nc;
    nc = (n > NCH - 1) ? NCH - 1 : n;
    exp_n = 0;
    if (t) begin exp_w[exp_n] = {4'b0, TEMP_V}; exp_n++; end
    case (scan)
      0: for (int c = 0; c <= nc; c++) begin exp_w[exp_n] = {4'b0, vsamp(c), 2'b00}; exp_n++; end
      1: for (int c = nc; c < NCH; c++) begin exp_w[exp_n] = {4'b0, vsamp(c), 2'b00}; exp_n++; end
      2: for (int r = 0; r < (nscan + 1) * 4; r++) begin exp_w[exp_n] = {4'b0, vsamp(nc), 2'b00}; exp_n++; end
      default: begin exp_w[exp_n] = {4'b0, vsamp(nc), 2'b00}; exp_n++; end
    endcase
  endtask

  task automatic read_check(string req, int nbytes);
    logic [7:0] d;
    fbegin();
    for (int k = 0; k < nbytes; k++) begin
      xfer(8'h00, d);
      check(req, int'(d), exp_byte(k));
    end
    fend();
  endtask

  task automatic run_conv(string req, logic [7:0] c, int scan, int n, bit t, int nscan);
    int lat;
    send_cmd(c);
    check("R10 eoc released on launch", int'(eoc_n), 1);
    wait_eoc(lat);
    check("R10 eoc falls at completion", int'(eoc_n), 0);
    build_exp(scan, n, t, nscan);
    read_check(req, exp_n * 2 + 2);
  endtask

  initial begin
    nchk = 0;
    nerr = 0;
    fork
      begin
        repeat (200000) @(posedge clk);
        nerr++;
        $display("FAIL watchdog expired");
        $display("CHECKS %0d ERRORS %0d", nchk, nerr);
        $finish;
      end
    join_none
  end

  initial begin
    int lat, e;
    logic [7:0] d;
    rst_n = 1'b0; sclk = 1'b0; cs_n = 1'b1; mosi = 1'b0; start_n = 1'b1;
    for (int i = 0; i < NCH; i++) samples[i*10 +: 10] = vsamp(i);
    waitc(5);
    rst_n = 1'b1;
    waitc(5);

    // reset state
    check("R10 eoc high after reset", int'(eoc_n), 1);
    check("R7 miso low after reset", int'(miso), 0);
    exp_n = 0;
    read_check("R8 no results after reset", 4);

    // command-triggered clock mode
    send_cmd(8'h68);

    // R6 single channel sweep
    for (int ch = 0; ch < NCH; ch++)
      run_conv("R6 single channel", 8'(8'h86 | (ch << 3)), 3, ch, 0, 0);

    // R3 low-up scan with temperature first (R7)
    for (int n = 0; n < NCH; n++)
      run_conv("R3 R7 scan 0..N with temp", 8'(8'h81 | (n << 3)), 0, n, 1, 0);

    // R4 N-to-top scan
    for (int n = 0; n < NCH; n++)
      run_conv("R4 scan N..top", 8'(8'h82 | (n << 3)), 1, n, 0, 0);

    // R5 repeat counts
    for (int ns = 0; ns < 4; ns++) begin
      send_cmd(8'(8'h20 | ns));
      run_conv("R5 repeated channel", 8'(8'h84 | (5 << 3) | ns[0]), 2, 5, ns[0], ns);
    end
    send_cmd(8'h20);

    // R2 out-of-range channel field clamps
    run_conv("R2 channel 12 clamps", 8'hE6, 3, 12, 0, 0);
    run_conv("R2 channel 15 scan up clamps", 8'hFA, 1, 15, 0, 0);
    run_conv("R2 channel 9 low-up clamps", 8'hC8, 0, 9, 0, 0);

    // R11 averaging length and value
    for (int na = 0; na < 4; na++) begin
      send_cmd(8'(8'h30 | (na << 2)));
      send_cmd(8'h97);
      wait_eoc(lat);
      e = 2 * (4 << na) * CC;
      check("R11 averaged conversion time lower", int'(lat >= e), 1);
      check("R11 averaged conversion time upper", int'(lat <= e + 8), 1);
      build_exp(3, 2, 1, 0);
      read_check("R11 averaged values", exp_n * 2);
    end
    send_cmd(8'h20);

    // R8 readout across frames and R1 ignored byte
    send_cmd(8'hA6);
    wait_eoc(lat);
    build_exp(3, 4, 0, 0);
    fbegin();
    xfer(8'h0F, d);
    fend();
    check("R1 R8 first byte while sending ignored byte", int'(d), exp_byte(0));
    check("R1 ignored byte keeps eoc low", int'(eoc_n), 0);
    fbegin();
    xfer(8'h00, d);
    check("R8 second byte in next frame", int'(d), exp_byte(1));
    xfer(8'h00, d);
    check("R8 past end reads zero", int'(d), 0);
    fend();

    // R9 external start mode
    send_cmd(8'h48);
    send_cmd(8'h8E);
    waitc(150);
    check("R9 conversion byte does not launch in external mode", int'(eoc_n), 0);
    start_n = 1'b0; waitc(4); start_n = 1'b1;
    waitc(10);
    check("R9 start edge launches", int'(eoc_n), 1);
    wait_eoc(lat);
    build_exp(3, 1, 0, 0);
    read_check("R9 externally started result", exp_n * 2 + 2);
    start_n = 1'b0; waitc(4); start_n = 1'b1;
    waitc(10);
    check("R9 second start edge relaunches", int'(eoc_n), 1);
    wait_eoc(lat);
    read_check("R9 relaunched result", exp_n * 2);
    send_cmd(8'h68);
    start_n = 1'b0; waitc(4); start_n = 1'b1;
    waitc(100);
    check("R9 start ignored in command mode", int'(eoc_n), 0);

    // R12 reset command
    send_cmd(8'h3C);
    send_cmd(8'h10);
    check("R12 eoc high after reset command", int'(eoc_n), 1);
    exp_n = 0;
    read_check("R12 results discarded", 4);
    send_cmd(8'h86);
    waitc(200);
    check("R12 clock mode cleared to external", int'(eoc_n), 1);
    send_cmd(8'h68);
    send_cmd(8'h86);
    wait_eoc(lat);
    check("R12 averaging cleared lower", int'(lat >= CC), 1);
    check("R12 averaging cleared upper", int'(lat <= CC + 8), 1);
    build_exp(3, 0, 0, 0);
    read_check("R12 result after reset", exp_n * 2);

    $display("CHECKS %0d ERRORS %0d", nchk, nerr);
    $finish;
  end

endmodule